// File: doc/BRIEF.md
# Two-Dimensional Half-Sample Interpolator

The block builds one predicted block of 8-bit pixels that sits half a sample away from the reference grid, both across and down. It runs in two separable passes, and both passes use the same four-tap kernel: minus one, nine, nine, minus one. The first pass filters the reference columns downward. Its results are signed 16-bit values, kept without any clamping, and they are held in an internal store. The second pass filters those values across. It re-centres the result, saturates it to 8 bits, and can optionally blend it with the pixel already present at the destination.

Operation has two phases, and they never overlap. In the load phase, the block takes a raster stream of reference pixels. The stream is BLK_H+3 rows of BLK_W+4 columns, starting one row above and one column left of the predicted block. The store is complete after the last reference pixel, and the block then switches to the emit phase. In that phase it offers BLK_W×BLK_H result pixels in raster order on a valid/ready port.

Back-pressure works as follows:
- A transfer takes place on any clock edge where valid and ready are both high.
- While the output is stalled, the offered pixel and its valid are held.
- The input ready is low for the whole emit phase.

The rounding value, the vertical shift and the averaging select are plain pins. They are captured with the first reference pixel of each block.

Top module: `ivc_hv_interp`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The load phase accepts exactly (BLK_W+4)×(BLK_H+3) pixels, in raster order, with row 0 one row above the block. On the edge that takes the last of them, `in_ready` falls and `out_valid` rises.
- R3: Intermediate (y, c) is formed from input rows y, y+1, y+2 and y+3 at column c. Its value is 9·(p[y+1]+p[y+2]) − p[y] − p[y+3] + rnd, wrapped to signed 16 bits, then arithmetic-shifted right by the captured shift (0 to 15), with no clamp.
- R4: Output (y, x) uses intermediates (y, x) through (y, x+3), where intermediate column 0 lies one left of output column 0. The value is 9·(m1+m2) − m0 − m3 + rnd − 16384, wrapped to signed 16 bits, arithmetic-shifted right by 7, plus 128.
- R5: Exactly BLK_W×BLK_H pixels leave in raster order. After the last transfer, `in_ready` is 1 again and `out_valid` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the offered pixel does not change.
- R7: With averaging captured as 1, the output is (new + `prev_pix` + 1) >> 1. Here `prev_pix` is the destination pixel supplied alongside the offered output.
- R8: `rnd_val`, `vshift` and `avg_en` are sampled only with the first accepted pixel of a block. Later changes have no effect on that block.
- R9: `in_ready` and `out_valid` are never high together, so input offered during the emit phase is not consumed.
- R10: The R4 value saturates to 0 when it is negative and to 255 when it is above 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Reference pixel offered |
| in_ready | output | 1 | Block is in the load phase |
| in_pix | input | 8 | Reference pixel, unsigned |
| rnd_val | input | 16 | Signed rounding value |
| vshift | input | 4 | Right shift of the vertical pass |
| avg_en | input | 1 | 1 blends the result with the destination pixel |
| prev_pix | input | 8 | Destination pixel paired with the offered output |
| out_valid | output | 1 | Result pixel offered |
| out_ready | input | 1 | Consumer accepts the result pixel |
| out_pix | output | 8 | Result pixel |

## Verification
The bench builds the block at its default 8×8 size, so each load is 132 pixels and each emit is 64 pixels. At that size every vertical shift from 0 to 15 and the full signed range of the rounding value can be reached. Flat white, flat black and checkerboard reference blocks drive the 16-bit wrap and both saturation limits. Random blocks are run with random input gaps and output stalls, and the configuration pins are scrambled in mid-block to check that they are captured once per block.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef logic signed [15:0] mid_t;
  typedef logic [7:0]         pix_t;

  localparam mid_t TAP_C  = 16'sd9;
  localparam mid_t H_BIAS = 16'sd16384;
  localparam mid_t H_LIFT = 16'sd128;
  localparam int   H_SHR  = 7;

  // zero-extend a pixel into a signed 16-bit lane
  function automatic mid_t widen(input pix_t p);
    return $signed({8'h00, p});
  endfunction

  // (-1, 9, 9, -1) kernel, modulo 2^16
  function automatic mid_t filt4(input mid_t a, input mid_t b, input mid_t c, input mid_t d);
    return TAP_C * (b + c) - a - d;
  endfunction
endpackage

// File: rtl/ivc_vpass.sv
module ivc_vpass
  import ivc_pkg::*;
#(
  parameter int COLS = 12
) (
  input  logic       clk,
  input  logic       push,
  input  pix_t       pix,
  input  mid_t       rnd,
  input  logic [3:0] shamt,
  output mid_t       mid
);
  localparam int DEPTH = 3 * COLS;

  // last three input rows; tap COLS*k-1 is the same column k rows back
  pix_t line_q [DEPTH];

  always_ff @(posedge clk) begin
    if (push) begin
      line_q[0] <= pix;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  mid_t acc;
  always_comb begin
    acc = filt4(widen(line_q[DEPTH-1]), widen(line_q[2*COLS-1]),
                widen(line_q[COLS-1]), widen(pix)) + rnd;
    mid = acc >>> shamt;
  end
endmodule

// File: rtl/ivc_hpass.sv
module ivc_hpass
  import ivc_pkg::*;
(
  input  mid_t t0,
  input  mid_t t1,
  input  mid_t t2,
  input  mid_t t3,
  input  mid_t rnd,
  input  logic avg,
  input  pix_t prev,
  output pix_t pix
);
  mid_t       acc, shd, lvl;
  pix_t       put;
  logic [8:0] sum;

  always_comb begin
    acc = filt4(t0, t1, t2, t3) + (rnd - H_BIAS);
    shd = acc >>> H_SHR;
    lvl = shd + H_LIFT;
    if (lvl < 16'sd0)        put = 8'h00;
    else if (lvl > 16'sd255) put = 8'hFF;
    else                     put = lvl[7:0];
    sum = {1'b0, put} + {1'b0, prev} + 9'd1;
    pix = avg ? sum[8:1] : put;
  end
endmodule

// File: rtl/ivc_hv_interp.sv
module ivc_hv_interp
  import ivc_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int BLK_H = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_pix,
  input  logic [15:0] rnd_val,
  input  logic [3:0]  vshift,
  input  logic        avg_en,
  input  logic [7:0]  prev_pix,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_pix
);
  localparam int COLS    = BLK_W + 4;
  localparam int IN_ROWS = BLK_H + 3;
  localparam int N_IN    = COLS * IN_ROWS;
  localparam int N_OUT   = BLK_W * BLK_H;
  localparam int N_MID   = COLS * BLK_H;
  localparam int CW      = $clog2(COLS);
  localparam int RW      = $clog2(IN_ROWS);
  localparam int XW      = $clog2(BLK_W);
  localparam int YW      = $clog2(BLK_H);

  typedef enum logic {ST_LOAD, ST_EMIT} st_t;
  st_t st_q;

  logic [CW-1:0] in_col;
  logic [RW-1:0] in_row;
  logic [XW-1:0] ox;
  logic [YW-1:0] oy;
  mid_t          rnd_q;
  logic [3:0]    sh_q;
  logic          avg_q;

  logic in_fire, out_fire, last_in, last_out, first_in;
  assign in_ready  = (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign last_in   = (int'(in_row) == IN_ROWS-1) && (int'(in_col) == COLS-1);
  assign last_out  = (int'(oy) == BLK_H-1) && (int'(ox) == BLK_W-1);
  assign first_in  = (in_row == '0) && (in_col == '0);

  // phase control, load counters and configuration capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      in_col <= '0;
      in_row <= '0;
      ox     <= '0;
      oy     <= '0;
      rnd_q  <= '0;
      sh_q   <= '0;
      avg_q  <= 1'b0;
    end else if (st_q == ST_LOAD) begin
      if (in_fire) begin
        if (first_in) begin
          rnd_q <= $signed(rnd_val);
          sh_q  <= vshift;
          avg_q <= avg_en;
        end
        if (int'(in_col) == COLS-1) begin
          in_col <= '0;
          in_row <= last_in ? '0 : in_row + 1'b1;
        end else begin
          in_col <= in_col + 1'b1;
        end
        if (last_in) st_q <= ST_EMIT;
      end
    end else if (out_fire) begin
      if (int'(ox) == BLK_W-1) begin
        ox <= '0;
        oy <= last_out ? '0 : oy + 1'b1;
      end else begin
        ox <= ox + 1'b1;
      end
      if (last_out) st_q <= ST_LOAD;
    end
  end

  // vertical pass
  mid_t mid_new;
  ivc_vpass #(.COLS(COLS)) u_vpass (
    .clk   (clk),
    .push  (in_fire),
    .pix   (in_pix),
    .rnd   (rnd_q),
    .shamt (sh_q),
    .mid   (mid_new)
  );

  // intermediate store, written once row 3 of the input is reached
  mid_t mid_mem [N_MID];
  logic mid_we;
  int   wr_idx;
  assign mid_we = in_fire && (int'(in_row) >= 3);
  always_comb wr_idx = (int'(in_row) - 3) * COLS + int'(in_col);

  always_ff @(posedge clk) begin
    if (mid_we) mid_mem[wr_idx] <= mid_new;
  end

  // horizontal pass taps
  int   rd_base;
  mid_t tap [4];
  always_comb begin
    rd_base = int'(oy) * COLS + int'(ox);
    for (int k = 0; k < 4; k++) tap[k] = mid_mem[rd_base + k];
  end

  ivc_hpass u_hpass (
    .t0   (tap[0]),
    .t1   (tap[1]),
    .t2   (tap[2]),
    .t3   (tap[3]),
    .rnd  (rnd_q),
    .avg  (avg_q),
    .prev (prev_pix),
    .pix  (out_pix)
  );
endmodule

// File: rtl/ivc_hv_interp_chk.sv
module ivc_hv_interp_chk #(
  parameter int N_IN  = 132,
  parameter int N_OUT = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_pix,
  input logic       avg_q
);
  int  n_in, n_out;
  logic in_fire, out_fire;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in  <= 0;
      n_out <= 0;
    end else begin
      if (in_fire)  n_in  <= (n_in == N_IN-1) ? 0 : n_in + 1;
      if (out_fire) n_out <= (n_out == N_OUT-1) ? 0 : n_out + 1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> in_ready && !out_valid);

  p_load_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && n_in == N_IN-1 |=> out_valid && !in_ready);

  p_load_cont_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && n_in != N_IN-1 |=> in_ready);

  p_emit_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && n_out == N_OUT-1 |=> in_ready && !out_valid);

  p_emit_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && n_out != N_OUT-1 |=> out_valid);

  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  p_hold_pix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !avg_q |=> $stable(out_pix));

  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != out_valid);
endmodule

bind ivc_hv_interp ivc_hv_interp_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix),
  .avg_q     (avg_q)
);

// File: tb/sim_ivc_hv_interp.sv
module sim_ivc_hv_interp;
  localparam int CLK_PERIOD = 10;
  localparam int BW      = 8;
  localparam int BH      = 8;
  localparam int COLS    = BW + 4;
  localparam int IN_ROWS = BH + 3;
  localparam int N_IN    = COLS * IN_ROWS;
  localparam int N_OUT   = BW * BH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_pix = '0;
  logic [15:0] rnd_val = '0;
  logic [3:0]  vshift = '0;
  logic        avg_en = 1'b0;
  logic [7:0]  prev_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivc_hv_interp #(.BLK_W(BW), .BLK_H(BH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .rnd_val(rnd_val), .vshift(vshift), .avg_en(avg_en),
    .prev_pix(prev_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix)
  );

  int checks = 0;
  int errors = 0;
  int refpix [N_IN];
  int expv   [N_OUT];
  int c_rnd, c_sh, c_avg;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    int t;
    t = v & 32'hFFFF;
    if (t >= 32768) t -= 65536;
    return t;
  endfunction

  // reference model built from the written requirements
  function automatic void model();
    int mid [BH][COLS];
    int t;
    for (int y = 0; y < BH; y++)
      for (int c = 0; c < COLS; c++)
        mid[y][c] = w16(9 * (refpix[(y+1)*COLS+c] + refpix[(y+2)*COLS+c])
                        - refpix[y*COLS+c] - refpix[(y+3)*COLS+c] + c_rnd) >>> c_sh;
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        t = w16(9 * (mid[y][x+1] + mid[y][x+2]) - mid[y][x] - mid[y][x+3]
                + c_rnd - 16384);
        t = (t >>> 7) + 128;
        if (t < 0) t = 0;
        if (t > 255) t = 255;
        expv[y*BW+x] = t;
      end
  endfunction

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // pat: 0 random, 1 all zero, 2 all 255, 3 checkerboard
  task automatic run_block(input string tag, input int pat, input int rnd,
                           input int sh, input int avg, input int gap_pct,
                           input int stall_pct, input bit scramble);
    int  idx;
    bit  stalled;
    logic [7:0] held;
    bit ok;
    for (int i = 0; i < N_IN; i++) begin
      case (pat)
        1: refpix[i] = 0;
        2: refpix[i] = 255;
        3: refpix[i] = (((i / COLS) + (i % COLS)) % 2 == 0) ? 255 : 0;
        default: refpix[i] = int'($urandom % 256);
      endcase
    end
    c_rnd = w16(rnd); c_sh = sh; c_avg = avg;
    model();
    rnd_val = 16'(rnd); vshift = 4'(sh); avg_en = avg[0];
    out_ready = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      while (int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pix = 8'(refpix[i]);
      forever begin
        ok = in_ready;
        @(negedge clk);
        if (ok) break;
      end
      if (scramble) begin  // R8: these must not reach this block
        rnd_val = 16'($urandom); vshift = 4'($urandom); avg_en = ~avg_en;
      end
    end
    chk("R2 out_valid after load", int'(out_valid), 1);
    chk("R2 in_ready after load", int'(in_ready), 0);
    // R9: keep offering junk during the emit phase
    in_valid = 1'b1;
    in_pix = 8'($urandom);
    idx = 0;
    stalled = 0;
    held = '0;
    prev_pix = 8'($urandom);
    while (idx < N_OUT) begin
      out_ready = (int'($urandom % 100) >= stall_pct);
      #1;
      if (stalled) begin
        chk("R6 valid held", int'(out_valid), 1);
        chk("R6 pixel held", int'(out_pix), int'(held));
      end
      stalled = 0;
      if (out_valid && out_ready) begin
        if (c_avg != 0)
          chk({tag, " R7"}, int'(out_pix), (expv[idx] + int'(prev_pix) + 1) >> 1);
        else
          chk(tag, int'(out_pix), expv[idx]);
        idx++;
        @(negedge clk);
        prev_pix = 8'($urandom);
      end else begin
        if (out_valid) begin
          held = out_pix;
          stalled = 1;
        end
        @(negedge clk);
      end
    end
    out_ready = 1'b0;
    in_valid = 1'b0;
    chk("R5 in_ready after emit", int'(in_ready), 1);
    chk("R5 out_valid after emit", int'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_sim();
    end
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);

    run_block("R3/R4 random", 0, 1, 4, 0, 0, 0, 0);
    run_block("R10 all zero", 1, 0, 0, 0, 10, 0, 0);
    run_block("R10 all white", 2, 0, 0, 0, 0, 20, 0);
    run_block("R10 checker", 3, 3, 1, 0, 0, 30, 0);
    run_block("R10 checker wide", 3, -200, 0, 0, 20, 0, 0);
    run_block("R4 average", 0, 7, 3, 1, 20, 40, 0);
    run_block("R4/R8 scrambled", 0, 2, 5, 0, 30, 30, 1);
    run_block("R4/R8 scrambled avg", 0, 31, 6, 1, 10, 50, 1);
    for (int b = 0; b < 6; b++)
      run_block("R3 random shift", 0, int'($urandom % 65536) - 32768,
                int'($urandom % 16), int'($urandom % 2), 25, 25, 0);
    done = 1;
    finish_sim();
  end
endmodule